// File: doc/BRIEF.md
# Flag-Conditioned Relative Branch Unit

This block sits in the fetch path of a small 16-bit processor. Each cycle it examines the current instruction word. If the word is a relative branch, it tests the status flags carry (C), sign (S), zero (Z) and negative (N) against the condition the word selects. It then produces the address of the next instruction to fetch. The unit owns the program-counter register, which is the current PC that every branch is measured from. When the advance enable is high, the register loads the computed next address on the clock edge.

The instruction word is split into four fields. The bit positions matter because the decode neighbour uses the same layout:

| Field | Bits |
|---|---|
| condition code | [15:12] |
| target register | [11:9] |
| modifier | [8:6] |
| offset magnitude | [5:0] |

A word is a branch when its target register is 7, the program-counter register, and its condition code is not 15. Code 15 is left for other special instructions. The offset is an unsigned magnitude. Bit 6, the lowest bit of the modifier, chooses whether it is added to or subtracted from the address of the next sequential word.

The condition evaluator is a single selection over a named enumeration of the sixteen codes. The block has no multi-cycle control, so its only sequential element is the PC register, which has two transitions. A synchronous reset loads the reset address. An advance loads the next address. Every other cycle holds the value.

Top module: `brx_unit`

## Requirements
- R1: `taken` is high only when instr[11:9] equals 7. For any other value of that field, `taken` is low and the instruction is treated as sequential.
- R2: For a branch word, condition codes 0 to 7 test one flag each:
  - codes 0 and 1 test C clear and C set;
  - codes 2 and 3 test S clear and S set;
  - codes 4 and 5 test Z clear and Z set;
  - codes 6 and 7 test N clear and N set.
- R3: Code 9 is taken when Z=0 and C=1, and code 8 is taken in every other flag state. Code 11 is taken when Z=0 and S=0, and code 10 is taken in every other flag state.
- R4: Code 12 is taken when N equals S. Code 13 is taken when N differs from S. Code 14 is taken whatever the flags are.
- R5: Code 15 never produces `taken`, whatever the flags or other fields are.
- R6: When `taken` is high and instr[6]=0, `next_pc` equals pc_q + 1 + instr[5:0], modulo 2^16.
- R7: When `taken` is high and instr[6]=1, `next_pc` equals pc_q + 1 - instr[5:0], modulo 2^16.
- R8: When `taken` is low, `next_pc` equals pc_q + 1, modulo 2^16.
- R9: A clock edge with `rst` high loads pc_q with RESET_PC (default 0), whatever `adv_en` is.
- R10: A clock edge with `rst` low and `adv_en` high loads pc_q with `next_pc`. With `adv_en` low, pc_q holds its value.
- R11: instr[8:7] has no effect on `taken` or `next_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance enable: the PC register takes next_pc |
| instr | input | 16 | Current instruction word |
| flag_c | input | 1 | Carry flag |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| taken | output | 1 | The current word is a branch whose condition holds |
| next_pc | output | 16 | Address of the next instruction |
| pc_q | output | 16 | Registered program counter |

## Verification
The hardest cases to bring about are the two wrap-around cases of the address arithmetic. One is a forward branch that crosses the top of the address space. The other is a backward branch that crosses zero. The PC can only be moved through the block's own branches, and it starts at zero. The stimulus therefore resets the unit and takes a backward branch of the largest magnitude, which wraps the PC close to the top of the address space. A forward branch of the largest magnitude then carries it past the top again. Random streams also mix resets, held cycles and random flags, so the PC wanders over much of the space.

// File: rtl/brx_pkg.sv
package brx_pkg;

    // Instruction field layout (shared with the decode neighbour)
    localparam int INSTR_W   = 16;
    localparam int CODE_W    = 4;
    localparam int REG_W     = 3;
    localparam int MOD_W     = 3;
    localparam int OFF_W     = 6;
    localparam int CODE_LSB  = OFF_W + MOD_W + REG_W;
    localparam int REG_LSB   = OFF_W + MOD_W;
    localparam int MOD_LSB   = OFF_W;
    localparam logic [REG_W-1:0] PC_REG_ID = 3'd7;

    typedef enum logic [CODE_W-1:0] {
        CC_CARRY_CLR = 4'h0,
        CC_CARRY_SET = 4'h1,
        CC_SIGN_CLR  = 4'h2,
        CC_SIGN_SET  = 4'h3,
        CC_ZERO_CLR  = 4'h4,
        CC_ZERO_SET  = 4'h5,
        CC_NEG_CLR   = 4'h6,
        CC_NEG_SET   = 4'h7,
        CC_NOT_HIGH  = 4'h8,
        CC_HIGH      = 4'h9,
        CC_NOT_GRT   = 4'hA,
        CC_GRT       = 4'hB,
        CC_NS_EQUAL  = 4'hC,
        CC_NS_DIFFER = 4'hD,
        CC_ALWAYS    = 4'hE,
        CC_SPECIAL   = 4'hF
    } cond_e;

    typedef struct packed {
        logic c;
        logic s;
        logic z;
        logic n;
    } flags_t;

    typedef struct packed {
        cond_e             code;
        logic              is_branch;
        logic              backward;
        logic [OFF_W-1:0]  magnitude;
    } br_fields_t;

endpackage

// File: rtl/brx_decode.sv
module brx_decode
    import brx_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output br_fields_t         fields
);
    logic [REG_W-1:0]  target_reg;
    logic [MOD_W-1:0]  modifier;
    logic              unused_mod_hi;

    always_comb begin
        target_reg       = instr[REG_LSB +: REG_W];
        modifier         = instr[MOD_LSB +: MOD_W];
        unused_mod_hi    = ^modifier[MOD_W-1:1];
        fields.code      = cond_e'(instr[CODE_LSB +: CODE_W]);
        fields.backward  = modifier[0];
        fields.magnitude = instr[OFF_W-1:0];
        fields.is_branch = (target_reg == PC_REG_ID) &&
                           (fields.code != CC_SPECIAL);
    end
endmodule

// File: rtl/brx_cond.sv
module brx_cond
    import brx_pkg::*;
(
    input  cond_e  code,
    input  flags_t flags,
    output logic   cond_true
);
    logic high_cmp;
    logic grt_cmp;

    always_comb begin
        high_cmp  = !flags.z && flags.c;
        grt_cmp   = !flags.z && !flags.s;
        cond_true = 1'b0;
        unique case (code)
            CC_CARRY_CLR: cond_true = !flags.c;
            CC_CARRY_SET: cond_true =  flags.c;
            CC_SIGN_CLR:  cond_true = !flags.s;
            CC_SIGN_SET:  cond_true =  flags.s;
            CC_ZERO_CLR:  cond_true = !flags.z;
            CC_ZERO_SET:  cond_true =  flags.z;
            CC_NEG_CLR:   cond_true = !flags.n;
            CC_NEG_SET:   cond_true =  flags.n;
            CC_NOT_HIGH:  cond_true = !high_cmp;
            CC_HIGH:      cond_true =  high_cmp;
            CC_NOT_GRT:   cond_true = !grt_cmp;
            CC_GRT:       cond_true =  grt_cmp;
            CC_NS_EQUAL:  cond_true = (flags.n == flags.s);
            CC_NS_DIFFER: cond_true = (flags.n != flags.s);
            CC_ALWAYS:    cond_true = 1'b1;
            CC_SPECIAL:   cond_true = 1'b0;
        endcase
    end
endmodule

// File: rtl/brx_target.sv
module brx_target
    import brx_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0]  pc_cur,
    input  logic             backward,
    input  logic [OFF_W-1:0] magnitude,
    output logic [PC_W-1:0]  seq_pc,
    output logic [PC_W-1:0]  branch_pc
);
    localparam int PAD_W = PC_W - OFF_W;

    logic [PC_W-1:0] ext_off;
    logic [PC_W-1:0] addend;
    logic [PC_W-1:0] carry_in;

    generate
        if (PAD_W > 0) begin : g_pad
            assign ext_off = {{PAD_W{1'b0}}, magnitude};
        end else begin : g_trunc
            assign ext_off = magnitude[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        seq_pc    = pc_cur + {{(PC_W-1){1'b0}}, 1'b1};
        addend    = ext_off ^ {PC_W{backward}};
        carry_in  = {{(PC_W-1){1'b0}}, backward};
        branch_pc = seq_pc + addend + carry_in;
    end
endmodule

// File: rtl/brx_pc_reg.sv
module brx_pc_reg #(
    parameter int              PC_W     = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv_en,
    input  logic [PC_W-1:0] pc_d,
    output logic [PC_W-1:0] pc_q
);
    typedef enum logic [1:0] {PCS_RESET, PCS_ADVANCE, PCS_HOLD} pc_act_e;
    pc_act_e act;

    always_comb begin
        if (rst)         act = PCS_RESET;
        else if (adv_en) act = PCS_ADVANCE;
        else             act = PCS_HOLD;
    end

    always_ff @(posedge clk) begin
        unique case (act)
            PCS_RESET:   pc_q <= RESET_PC;
            PCS_ADVANCE: pc_q <= pc_d;
            default:     pc_q <= pc_q;
        endcase
    end
endmodule

// File: rtl/brx_unit.sv
module brx_unit
    import brx_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv_en,
    input  logic [INSTR_W-1:0]  instr,
    input  logic                flag_c,
    input  logic                flag_s,
    input  logic                flag_z,
    input  logic                flag_n,
    output logic                taken,
    output logic [PC_W-1:0]     next_pc,
    output logic [PC_W-1:0]     pc_q
);
    br_fields_t      fields;
    flags_t          flags;
    logic            cond_true;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] branch_pc;

    assign flags = '{c: flag_c, s: flag_s, z: flag_z, n: flag_n};

    brx_decode decode_i (
        .instr  (instr),
        .fields (fields)
    );

    brx_cond cond_i (
        .code      (fields.code),
        .flags     (flags),
        .cond_true (cond_true)
    );

    brx_target #(.PC_W(PC_W)) target_i (
        .pc_cur    (pc_q),
        .backward  (fields.backward),
        .magnitude (fields.magnitude),
        .seq_pc    (seq_pc),
        .branch_pc (branch_pc)
    );

    always_comb begin
        taken   = fields.is_branch && cond_true;
        next_pc = taken ? branch_pc : seq_pc;
    end

    brx_pc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) pc_reg_i (
        .clk    (clk),
        .rst    (rst),
        .adv_en (adv_en),
        .pc_d   (next_pc),
        .pc_q   (pc_q)
    );
endmodule

// File: rtl/brx_unit_chk.sv
module brx_unit_chk #(
    parameter int              PC_W     = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input logic            clk,
    input logic            rst,
    input logic            adv_en,
    input logic [15:0]     instr,
    input logic            flag_c,
    input logic            flag_s,
    input logic            flag_z,
    input logic            flag_n,
    input logic            taken,
    input logic [PC_W-1:0] next_pc,
    input logic [PC_W-1:0] pc_q
);
    localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

    logic [PC_W-1:0] mag_ext;
    assign mag_ext = {{(PC_W-6){1'b0}}, instr[5:0]};

    assert_target_reg_R1: assert property (@(posedge clk) disable iff (rst)
        taken |-> (instr[11:9] == 3'd7));

    assert_zero_set_R2: assert property (@(posedge clk) disable iff (rst)
        (instr[15:12] == 4'h5 && instr[11:9] == 3'd7 && flag_z) |-> taken);

    assert_high_R3: assert property (@(posedge clk) disable iff (rst)
        (instr[15:12] == 4'h9 && instr[11:9] == 3'd7 && !flag_z && flag_c) |-> taken);

    assert_always_R4: assert property (@(posedge clk) disable iff (rst)
        (instr[15:12] == 4'hE && instr[11:9] == 3'd7) |-> taken);

    assert_reserved_R5: assert property (@(posedge clk) disable iff (rst)
        (instr[15:12] == 4'hF) |-> !taken);

    assert_forward_R6: assert property (@(posedge clk) disable iff (rst)
        (taken && !instr[6]) |-> (next_pc == pc_q + ONE + mag_ext));

    assert_backward_R7: assert property (@(posedge clk) disable iff (rst)
        (taken && instr[6]) |-> (next_pc == pc_q + ONE - mag_ext));

    assert_sequential_R8: assert property (@(posedge clk) disable iff (rst)
        !taken |-> (next_pc == pc_q + ONE));

    assert_reset_load_R9: assert property (@(posedge clk)
        rst |=> (pc_q == RESET_PC));

    assert_advance_R10: assert property (@(posedge clk) disable iff (rst)
        adv_en |=> (pc_q == $past(next_pc)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> $stable(pc_q));
endmodule

bind brx_unit brx_unit_chk #(.PC_W(PC_W), .RESET_PC(RESET_PC)) chk_i (.*);

// File: tb/brx_unit_tb_top.sv
`timescale 1ns/1ps
module brx_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_en = 1'b0;
    logic [15:0] instr = '0;
    logic        flag_c = 1'b0, flag_s = 1'b0, flag_z = 1'b0, flag_n = 1'b0;
    logic        taken;
    logic [15:0] next_pc;
    logic [15:0] pc_q;

    int  errors = 0;
    int  checks = 0;
    int  model_pc = 0;
    bit  model_valid = 0;
    bit  last_rst = 0;
    bit  finished = 0;

    always #5 clk = ~clk;

    brx_unit dut_i (
        .clk(clk), .rst(rst), .adv_en(adv_en), .instr(instr),
        .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z), .flag_n(flag_n),
        .taken(taken), .next_pc(next_pc), .pc_q(pc_q)
    );

    function automatic logic [15:0] mk(int code, int rg, int md, int off);
        return {code[3:0], rg[2:0], md[2:0], off[5:0]};
    endfunction

    // Reference meaning of each condition code
    function automatic bit ref_cond(int code, bit c, bit s, bit z, bit n);
        if (code == 0)  return c == 0;
        if (code == 1)  return c == 1;
        if (code == 2)  return s == 0;
        if (code == 3)  return s == 1;
        if (code == 4)  return z == 0;
        if (code == 5)  return z == 1;
        if (code == 6)  return n == 0;
        if (code == 7)  return n == 1;
        if (code == 8)  return !(z == 0 && c == 1);
        if (code == 9)  return  (z == 0 && c == 1);
        if (code == 10) return !(z == 0 && s == 0);
        if (code == 11) return  (z == 0 && s == 0);
        if (code == 12) return n == s;
        if (code == 13) return n != s;
        if (code == 14) return 1;
        return 0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(bit r, bit en, logic [15:0] ins, logic [3:0] fl);
        int  code, rg, mag, exp_next;
        bit  dir, exp_taken;
        string tag_t, tag_n;
        @(negedge clk);
        rst = r; adv_en = en; instr = ins;
        {flag_c, flag_s, flag_z, flag_n} = fl;
        #1;
        code = int'(ins[15:12]); rg = int'(ins[11:9]);
        dir = ins[6]; mag = int'(ins[5:0]);
        exp_taken = (rg == 7) && (code != 15) &&
                    ref_cond(code, fl[3], fl[2], fl[1], fl[0]);
        exp_next = model_pc + 1;
        if (exp_taken) exp_next = dir ? exp_next - mag : exp_next + mag;
        exp_next = ((exp_next % 65536) + 65536) % 65536;
        if (model_valid && !r) begin
            if (rg != 7)        tag_t = "R1";
            else if (code == 15) tag_t = "R5";
            else if (code < 8)   tag_t = "R2";
            else if (code < 12)  tag_t = "R3";
            else                 tag_t = "R4";
            check(taken === exp_taken, tag_t, int'(taken), int'(exp_taken), "taken");
            if (!exp_taken)     tag_n = "R8";
            else if (dir)       tag_n = "R7";
            else                tag_n = "R6";
            if (ins[8:7] != 2'b00) tag_n = {tag_n, " R11"};
            check(next_pc === exp_next[15:0], tag_n, int'(next_pc), exp_next, "next_pc");
        end
        if (model_valid)
            check(pc_q === model_pc[15:0], last_rst ? "R9" : "R10",
                  int'(pc_q), model_pc, "pc_q");
        @(posedge clk);
        if (r) begin model_pc = 0; model_valid = 1; end
        else if (en && model_valid) model_pc = exp_next;
        last_rst = r;
    endtask

    initial begin
        #(100000 * 10);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        step(1, 0, '0, '0);
        step(1, 1, mk(14, 7, 0, 9), '0);
        // R10: hold with an always-taken branch presented
        for (int i = 0; i < 4; i++) step(0, 0, mk(14, 7, 0, 5), 4'hF);
        step(0, 1, mk(14, 7, 0, 5), '0);
        // R2 R3 R4 R5: every code against every flag state
        for (int code = 0; code < 16; code++)
            for (int fl = 0; fl < 16; fl++)
                step(0, 1, mk(code, 7, $urandom_range(0, 1), $urandom_range(0, 63)), fl[3:0]);
        // R1: other target registers never branch
        for (int rg = 0; rg < 7; rg++)
            for (int code = 0; code < 16; code++)
                step(0, 1, mk(code, rg, 0, 40), 4'b0101);
        // R7 then R6: wrap below zero, then past the top
        step(1, 0, '0, '0);
        step(0, 1, mk(14, 7, 1, 63), '0);
        step(0, 1, mk(14, 7, 0, 63), '0);
        step(0, 1, mk(14, 7, 1, 0), '0);
        step(0, 1, mk(14, 7, 1, 1), '0);
        // R11: upper modifier bits do not matter
        for (int md = 0; md < 8; md++) step(0, 1, mk(9, 7, md, 17), 4'b1000);
        for (int md = 0; md < 8; md++) step(0, 1, mk(1, 7, md, 3), 4'b0000);
        // Random stream with held cycles and occasional reset
        for (int i = 0; i < 4000; i++)
            step($urandom_range(0, 99) == 0, $urandom_range(0, 3) != 0,
                 16'($urandom), 4'($urandom));
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule